// File: doc/BRIEF.md
# Read Strobe Postamble Gate

This block sits on the read path of a double-data-rate memory interface, after the phase-shifted read strobe and in front of the data capture flops. The strobe from the memory is driven low just before a burst (the preamble) and again just after it (the postamble), and it floats in between bursts. While it floats, noise can look like edges. The block passes the strobe through only while a read burst is expected and forces it low from the last falling strobe edge of the burst onward, so that any later strobe activity cannot clock the capture flops.

The controller raises a read window on the system clock at least one cycle before the first rising strobe edge and selects a short or a long burst. The window is registered on the system clock to arm the gate. The burst length is latched when the window first appears. A small counter clocked by falling edges of the gated strobe counts strobe cycles and sets a close flag on the last one. Because that edge is a falling edge, the gated strobe is already low when the gate shuts. Dropping the window clears the counter and the close flag for the next burst. The data bus is sampled on both edges of the gated strobe, and each rising and falling word is presented together as a pair.

Top module: `rd_strobe_gate`

## Requirements
- R1: While reset is high and after its release, the gated strobe is low and both pair words are zero.
- R2: While the armed state is low, the gated strobe stays low and strobe pulses change neither pair word.
- R3: The gate arms on the first system clock rising edge at which the read window is sampled high. A strobe pulse before that edge is blocked.
- R4: While armed and before the burst ends, the gated strobe follows the raw strobe.
- R5: At each falling edge of the gated strobe, the high pair word becomes the data sampled at the preceding rising edge, and the low pair word becomes the data at that falling edge.
- R6: The burst length select is 1 for 8 beats (4 strobe cycles) and 0 for 4 beats (2 strobe cycles). It is latched on the clock edge that arms the gate, and later changes have no effect on the current burst. The gate closes on the falling edge that ends the last strobe cycle.
- R7: After the gate closes and while the window is still high, strobe glitches leave the gated strobe low and the pair unchanged.
- R8: When the window is sampled low, the gate disarms and clears its closed state, so that a following burst is captured in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| rd_win_i | input | 1 | Read window from the controller |
| bl8_i | input | 1 | Burst select: 1 for 8 beats, 0 for 4 beats |
| dqs_i | input | 1 | Phase-shifted read strobe |
| dq_i | input | DQ_W | Read data bus |
| dqs_gated_o | output | 1 | Gated strobe |
| pair_hi_o | output | DQ_W | Word captured on the rising edge |
| pair_lo_o | output | DQ_W | Word captured on the falling edge |

## Verification
The armed state takes effect one system clock edge after the window is sampled. The bench changes the window at a falling clock edge and probes the strobe only after the following rising edge, with one probe deliberately placed before that edge. The gated strobe is combinational from the raw strobe, so the bench samples it one time unit after each raw edge. The pair updates at the falling strobe edge itself and is read one unit later. Every burst is followed by glitches, first with the window still high and then after it drops, and the bench compares the pair with the last expected words each time.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
    // falling strobe edges that end a burst of the given beat count
    function automatic int falls_for(input int beats);
        return beats / 2;
    endfunction
endpackage

// File: rtl/rsg_window.sv
module rsg_window #(
    parameter int BEATS_SHORT = 4,
    parameter int BEATS_LONG  = 8,
    localparam int CW = $clog2(rsg_pkg::falls_for(BEATS_LONG) + 1)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          rd_win_i,
    input  logic          bl8_i,
    output logic          arm_o,
    output logic [CW-1:0] lim_o
);
    typedef struct packed {
        logic arm;
        logic long_sel;
    } win_t;

    win_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.arm      = rd_win_i;
        if (rd_win_i && !st_q.arm)
            st_d.long_sel = bl8_i;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign arm_o = st_q.arm;
    assign lim_o = st_q.long_sel ? CW'(rsg_pkg::falls_for(BEATS_LONG))
                                 : CW'(rsg_pkg::falls_for(BEATS_SHORT));

    // R3
    arm_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(arm_o) |-> $past(rd_win_i));
    // R8
    disarm_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_win_i |=> !arm_o);
endmodule

// File: rtl/rsg_gate.sv
module rsg_gate #(
    parameter int CW = 3
) (
    input  logic          strb_g_i,
    input  logic          clr_i,
    input  logic [CW-1:0] lim_i,
    output logic          close_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          close;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cnt   = st_q.cnt + 1'b1;
        st_d.close = (st_d.cnt == lim_i);
    end

    // clocked by the strobe path itself, cleared while disarmed
    always_ff @(negedge strb_g_i or posedge clr_i) begin
        if (clr_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign close_o = st_q.close;

    // R6
    cnt_bound_chk: assert property (@(negedge strb_g_i) disable iff (clr_i)
        st_q.cnt < lim_i);
    // R7
    no_edge_closed_chk: assert property (@(posedge strb_g_i) disable iff (clr_i)
        !st_q.close);
endmodule

// File: rtl/rsg_capture.sv
module rsg_capture #(
    parameter int DQ_W = 8
) (
    input  logic            strb_g_i,
    input  logic            rst_i,
    input  logic [DQ_W-1:0] dq_i,
    output logic [DQ_W-1:0] hi_o,
    output logic [DQ_W-1:0] lo_o
);
    typedef struct packed {
        logic [DQ_W-1:0] hi;
        logic [DQ_W-1:0] lo;
    } pair_t;

    logic [DQ_W-1:0] rise_d, rise_q;
    pair_t           pair_d, pair_q;

    always_comb begin
        rise_d    = dq_i;
        pair_d.hi = rise_q;
        pair_d.lo = dq_i;
    end

    always_ff @(posedge strb_g_i or posedge rst_i) begin
        if (rst_i) rise_q <= '0;
        else       rise_q <= rise_d;
    end

    always_ff @(negedge strb_g_i or posedge rst_i) begin
        if (rst_i) pair_q <= '0;
        else       pair_q <= pair_d;
    end

    assign hi_o = pair_q.hi;
    assign lo_o = pair_q.lo;
endmodule

// File: rtl/rd_strobe_gate.sv
module rd_strobe_gate #(
    parameter int DQ_W        = 8,
    parameter int BEATS_SHORT = 4,
    parameter int BEATS_LONG  = 8,
    localparam int CW = $clog2(rsg_pkg::falls_for(BEATS_LONG) + 1)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            rd_win_i,
    input  logic            bl8_i,
    input  logic            dqs_i,
    input  logic [DQ_W-1:0] dq_i,
    output logic            dqs_gated_o,
    output logic [DQ_W-1:0] pair_hi_o,
    output logic [DQ_W-1:0] pair_lo_o
);
    logic          arm;
    logic [CW-1:0] lim;
    logic          close;
    logic          clr;

    rsg_window #(.BEATS_SHORT(BEATS_SHORT), .BEATS_LONG(BEATS_LONG)) u_win (
        .clk_i(clk_i), .rst_i(rst_i), .rd_win_i(rd_win_i), .bl8_i(bl8_i),
        .arm_o(arm), .lim_o(lim)
    );

    assign clr         = rst_i | ~arm;
    assign dqs_gated_o = dqs_i & arm & ~close;

    rsg_gate #(.CW(CW)) u_gate (
        .strb_g_i(dqs_gated_o), .clr_i(clr), .lim_i(lim), .close_o(close)
    );

    rsg_capture #(.DQ_W(DQ_W)) u_cap (
        .strb_g_i(dqs_gated_o), .rst_i(rst_i), .dq_i(dq_i),
        .hi_o(pair_hi_o), .lo_o(pair_lo_o)
    );

    // R2
    idle_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !arm |-> !dqs_gated_o);
endmodule

// File: tb/tb_rd_strobe_gate.sv
module tb_rd_strobe_gate;
    localparam int CLK_P = 10;
    localparam int DQ_W  = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            rd_win = 1'b0;
    logic            bl8 = 1'b0;
    logic            dqs = 1'b0;
    logic [DQ_W-1:0] dq = '0;
    logic            dqs_g;
    logic [DQ_W-1:0] hi, lo;

    int checks = 0;
    int fails  = 0;
    logic [DQ_W-1:0] exp_hi = '0, exp_lo = '0;

    always #(CLK_P/2) clk = ~clk;

    rd_strobe_gate #(.DQ_W(DQ_W)) dut (
        .clk_i(clk), .rst_i(rst), .rd_win_i(rd_win), .bl8_i(bl8),
        .dqs_i(dqs), .dq_i(dq), .dqs_gated_o(dqs_g),
        .pair_hi_o(hi), .pair_lo_o(lo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DQ_W-1:0] word(input int b, input int i);
        return DQ_W'(b * 37 + i * 11 + 5);
    endfunction

    // one strobe pulse carrying data, gated strobe expected as given
    task automatic pulse(input string req, input logic [DQ_W-1:0] w_r,
                         input logic [DQ_W-1:0] w_f, input logic exp_g);
        dq = w_r; #1; dqs = 1'b1; #1;
        chk(req, dqs_g, exp_g);
        #1; dq = w_f; #1; dqs = 1'b0; #1;
        chk(req, dqs_g, 1'b0);
    endtask

    task automatic burst(input int b, input logic long_sel);
        int ncyc;
        ncyc = long_sel ? 4 : 2;
        @(negedge clk); rd_win = 1'b1; bl8 = long_sel;
        // R3: pulse before the arming edge is blocked
        #1; pulse("R3", 8'hEE, 8'hDD, 1'b0);
        chk("R3", hi, exp_hi); chk("R3", lo, exp_lo);
        @(posedge clk); #1;
        bl8 = ~long_sel; // R6: must not alter the latched length
        for (int k = 0; k < ncyc; k++) begin
            pulse("R4", word(b, 2*k), word(b, 2*k+1), 1'b1);
            exp_hi = word(b, 2*k); exp_lo = word(b, 2*k+1);
            chk("R5", hi, exp_hi); chk("R5", lo, exp_lo);
        end
        // R6/R7: gate closed after the last falling edge
        for (int g = 0; g < 3; g++) begin
            pulse("R7", 8'h5A, 8'hA5, 1'b0);
            chk("R7", hi, exp_hi); chk("R7", lo, exp_lo);
        end
        @(negedge clk); rd_win = 1'b0;
        @(posedge clk); #1;
        // R2: disarmed, glitches blocked
        pulse("R2", 8'h33, 8'hCC, 1'b0);
        chk("R2", hi, exp_hi); chk("R2", lo, exp_lo);
    endtask

    initial begin
        #(CLK_P * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 2 + 1);
        // R1: reset state
        chk("R1", dqs_g, 1'b0); chk("R1", hi, 0); chk("R1", lo, 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1", hi, 0); chk("R1", lo, 0);
        // R2: no window, pulses ignored
        pulse("R2", 8'h11, 8'h22, 1'b0);
        chk("R2", hi, 0); chk("R2", lo, 0);
        // R8: consecutive bursts of both lengths each capture fully
        for (int b = 0; b < 8; b++) begin
            burst(b, b[0]);
            chk("R8", hi, word(b, (b[0] ? 7 : 3) - 1));
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule